// File: doc/BRIEF.md
# Time-of-Day Counter (Hours, Minutes, Seconds)

This block keeps the time of day as three cascaded modulo counters sharing one clock: a seconds stage that counts modulo 60, a minutes stage that counts modulo 60, and an hours stage that counts modulo 24. A single `tick` input, pulsed once per second by the surrounding logic, advances the seconds stage. Each stage has its own rollover output. That output is high in the cycle where the stage's increment is asserted while it sits at its last value. Each rollover drives the increment of the stage above it, so every digit changes on the same clock edge and no stage is clocked by another.

The rollover of the hours stage is brought out as `day_o`. It pulses for the one cycle in which the time passes from 23:59:59 to 00:00:00. A synchronous clear returns all three stages to zero and suppresses every rollover while it is asserted. The clear doubles as the block's initialisation: the counters hold no defined value until `clr` has been high for at least one clock edge.

Top module: `tod_counter`

## Requirements
- R1: The seconds output `sec_o` advances by one on each clock edge where `tick` is high, and returns from 59 to 0.
- R2: The minutes output `min_o` advances by one exactly on the edges where `tick` is high and `sec_o` is 59, returns from 59 to 0, and holds on all other edges.
- R3: The hours output `hr_o` advances by one exactly on the edges where `tick` is high, `sec_o` is 59 and `min_o` is 59, returns from 23 to 0, and holds on all other edges.
- R4: On an edge where `tick` is low and `clr` is low, all three value outputs keep their values.
- R5: On an edge where `clr` is high, all three value outputs become 0, whatever the values of `tick` and of the current time.
- R6: `day_o` is combinational and is high exactly when `tick` is high, `clr` is low and the time is 23:59:59.
- R7: While `clr` is high every rollover is held low, so no stage above the seconds stage advances and `day_o` is low.
- R8: After a clear, `sec_o` and `min_o` never exceed 59 and `hr_o` never exceeds 23.
- R9: From 23:59:59 with `tick` high and `clr` low, the next edge gives 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three stages |
| clr | input | 1 | Synchronous clear; zeroes all stages and takes priority over `tick` |
| tick | input | 1 | One-cycle pulse per second; the increment for the seconds stage |
| sec_o | output | 6 | Seconds value, 0 to 59 |
| min_o | output | 6 | Minutes value, 0 to 59 |
| hr_o | output | 5 | Hours value, 0 to 23 |
| day_o | output | 1 | Rollover of the hours stage; high for the cycle that wraps to midnight |

## Verification
On every cycle, the assertions check the step rules of each stage. These are the increment and wrap of the seconds stage, the advance or hold of the minutes stage as a function of the seconds rollover, the range limits, the hold when `tick` is low, the forced zero after a clear and the silence of the rollovers during a clear. What the per-cycle properties cannot show is the whole cascade over a full day. The bench sweeps all 86,400 states of the day against a seconds-since-midnight model, with hold cycles scattered through the sweep. It then checks that the midnight wrap produces exactly one `day_o` pulse, and that a clear applied at 00:59:59 with `tick` high beats both the increment and the pending carries.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned SEC_MOD = 60;
  localparam int unsigned MIN_MOD = 60;
  localparam int unsigned HR_MOD  = 24;

  localparam int unsigned SEC_W = $clog2(SEC_MOD);
  localparam int unsigned MIN_W = $clog2(MIN_MOD);
  localparam int unsigned HR_W  = $clog2(HR_MOD);

  // Next value of a modulo counter: wraps to 0 after modulus-1.
  function automatic int unsigned mod_step(input int unsigned cur, input int unsigned modulus);
    return (cur == modulus - 1) ? 0 : cur + 1;
  endfunction

  // True when a stage sits at its last value.
  function automatic logic at_last(input int unsigned cur, input int unsigned modulus);
    return cur == modulus - 1;
  endfunction
endpackage

// File: rtl/tod_stage.sv
module tod_stage
  import tod_pkg::*;
#(
  parameter int unsigned MODULUS = 60,
  localparam int unsigned W = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         roll
);
  logic last_w;

  assign last_w = at_last(int'(val), MODULUS);
  // Mealy carry: this stage wraps on the coming edge; silenced by clear.
  assign roll   = inc & last_w & ~clr;

  always_ff @(posedge clk) begin
    if (clr)
      val <= '0;
    else if (inc)
      val <= W'(mod_step(int'(val), MODULUS));
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             tick,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o,
  output logic             day_o
);
  logic sec_roll;
  logic min_roll;
  logic hr_roll;

  tod_stage #(.MODULUS(SEC_MOD)) u_sec (
    .clk(clk), .clr(clr), .inc(tick),     .val(sec_o), .roll(sec_roll)
  );

  tod_stage #(.MODULUS(MIN_MOD)) u_min (
    .clk(clk), .clr(clr), .inc(sec_roll), .val(min_o), .roll(min_roll)
  );

  tod_stage #(.MODULUS(HR_MOD)) u_hr (
    .clk(clk), .clr(clr), .inc(min_roll), .val(hr_o),  .roll(hr_roll)
  );

  assign day_o = hr_roll;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
(
  input logic             clk,
  input logic             clr,
  input logic             tick,
  input logic [SEC_W-1:0] sec_o,
  input logic [MIN_W-1:0] min_o,
  input logic [HR_W-1:0]  hr_o,
  input logic             sec_roll,
  input logic             min_roll,
  input logic             day_o
);
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (clr)
    (tick && sec_o != SEC_W'(SEC_MOD - 1)) |=> (sec_o == $past(sec_o) + 1'b1)); // R1
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (clr)
    (tick && sec_o == SEC_W'(SEC_MOD - 1)) |=> (sec_o == '0)); // R1
  AST_MIN_ADV: assert property (@(posedge clk) disable iff (clr)
    sec_roll |=> (min_o == (($past(min_o) == MIN_W'(MIN_MOD - 1)) ? '0 : $past(min_o) + 1'b1))); // R2
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (clr)
    !sec_roll |=> $stable(min_o)); // R2
  AST_HR_HOLD: assert property (@(posedge clk) disable iff (clr)
    !min_roll |=> $stable(hr_o)); // R3
  AST_HOLD_ALL: assert property (@(posedge clk) disable iff (clr)
    !tick |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o))); // R4
  AST_CLR_ZERO: assert property (@(posedge clk)
    clr |=> (sec_o == '0 && min_o == '0 && hr_o == '0)); // R5
  AST_DAY_WHEN: assert property (@(posedge clk) disable iff (clr)
    day_o |-> (tick && sec_o == SEC_W'(SEC_MOD - 1) && min_o == MIN_W'(MIN_MOD - 1)
               && hr_o == HR_W'(HR_MOD - 1))); // R6
  AST_CLR_QUIET: assert property (@(posedge clk)
    clr |-> (!sec_roll && !min_roll && !day_o)); // R7
  AST_RANGE: assert property (@(posedge clk) disable iff (clr)
    (sec_o < SEC_W'(SEC_MOD) && min_o < MIN_W'(MIN_MOD) && hr_o < HR_W'(HR_MOD))); // R8
  AST_MIDNIGHT: assert property (@(posedge clk) disable iff (clr)
    day_o |=> (sec_o == '0 && min_o == '0 && hr_o == '0)); // R9
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .clr(clr), .tick(tick),
  .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
  .sec_roll(sec_roll), .min_roll(min_roll), .day_o(day_o)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  localparam int CLK_P   = 10;
  localparam int DAY_S   = 86400;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hr_o;
  logic       day_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  int cycles = 0;
  bit done   = 0;

  tod_counter uut (
    .clk(clk), .clr(clr), .tick(tick),
    .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .day_o(day_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, model);
    end
  endtask

  task automatic check_time(input string rs, input string rm, input string rh);
    check(rs, "seconds", int'(sec_o), model % 60);
    check(rm, "minutes", int'(min_o), (model / 60) % 60);
    check(rh, "hours",   int'(hr_o),  model / 3600);
  endtask

  // One clock: drive at negedge, check day_o before the edge, update model, check state after.
  task automatic step(input logic t, input logic c, input string day_req);
    int  prev;
    bit  wrapped;
    @(negedge clk);
    tick = t;
    clr  = c;
    #(CLK_P/4);
    check(day_req, "day_o", int'(day_o), (t && !c && model == DAY_S - 1) ? 1 : 0);
    @(posedge clk);
    prev    = model;
    wrapped = t && !c && prev == DAY_S - 1;
    if (c)      model = 0;
    else if (t) model = (model + 1) % DAY_S;
    #(CLK_P/4);
    if (c)                       check_time("R5", "R5", "R5");
    else if (wrapped)            check_time("R9", "R9", "R9");
    else if (!t)                 check_time("R4", "R4", "R4");
    else if (prev % 60 != 59)    check_time("R1", "R2", "R3");
    else if (prev % 3600 != 3599) check_time("R1", "R2", "R3");
    else                         check_time("R1", "R2", "R3");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    // Reset state through clear (R5)
    step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    check("R5", "reset seconds", int'(sec_o), 0);
    check("R5", "reset minutes", int'(min_o), 0);
    check("R5", "reset hours",   int'(hr_o),  0);

    // Full day sweep up to 23:59:59, hold cycles scattered (R1, R2, R3, R4, R6, R8)
    for (int i = 0; i < DAY_S - 1; i++) begin
      if (i % 997 == 500) step(1'b0, 1'b0, "R6");
      step(1'b1, 1'b0, "R6");
    end
    check("R8", "at 23:59:59 hours", int'(hr_o), 23);

    // Hold at the last second: no day pulse (R4, R6)
    step(1'b0, 1'b0, "R6");
    // Midnight wrap with day pulse (R9, R6)
    step(1'b1, 1'b0, "R6");
    check("R9", "after wrap seconds", int'(sec_o), 0);

    // Run to 00:59:59, then clear together with tick (R5, R7)
    for (int i = 0; i < 3599; i++) step(1'b1, 1'b0, "R6");
    check("R2", "at 00:59:59 minutes", int'(min_o), 59);
    step(1'b1, 1'b1, "R7");
    check("R7", "no carry under clear hours", int'(hr_o), 0);

    // Resume counting after clear (R1)
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R6");
    check("R1", "seconds after resume", int'(sec_o), 5);

    finish_run();
  end
endmodule